// File: doc/BRIEF.md
# Supervisory Reset Sequencer

This block turns digitized supply comparator results and a push-button request into the system reset and the supply warning flags. The primary-supply comparator and the manual request both force reset low. Once every cause has cleared, reset is held low for a fixed number of ticks of a free-running millisecond strobe and then released. The same stretch applies after power-on clear. Any cause that returns during the stretch starts the count again from zero.

The lowline flag and the secondary-fail flag carry no delay. Each follows its comparator in the same cycle. The manual request is asynchronous, so it passes through a two-flop synchronizer and a tick-based debounce before it is used. While reset is low, a bus-inhibit output blocks the serial interface. The stretch length and the debounce length are parameters, both counted in ticks.

Top module: `supv_reset_seq`

## Requirements
- R1: While `pri_low` is 1, `rst_n` is 0 in that same cycle.
- R2: After the last cause clears, `rst_n` stays 0 until STRETCH_TICKS tick pulses have been seen with no cause present. It rises in the cycle after the clock edge that samples the last of those ticks.
- R3: After `por_n` is released with the supplies good, `rst_n` is 0 and rises after STRETCH_TICKS tick pulses.
- R4: An accepted manual request drives `rst_n` to 0. Once the request is accepted as released, `rst_n` stays 0 for a further STRETCH_TICKS ticks.
- R5: `mrst_n` goes through a two-flop synchronizer. A change is accepted only after it has been stable for DEBOUNCE_TICKS ticks. A low pulse that covers fewer ticks leaves `rst_n` high.
- R6: `lowline_n` equals the inverse of `pri_low` in every cycle, with no stretch.
- R7: `secfail_n` equals the inverse of `sec_low` in every cycle, including during reset.
- R8: `bus_inhibit` is 1 exactly when `rst_n` is 0.
- R9: If a cause reasserts partway through the stretch, the stretch restarts. The full STRETCH_TICKS ticks are needed again after it clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on clear, active low |
| tick | input | 1 | One-cycle millisecond strobe |
| pri_low | input | 1 | Primary supply below trip |
| sec_low | input | 1 | Secondary monitor below trip |
| mrst_n | input | 1 | Manual reset request, active low, asynchronous |
| rst_n | output | 1 | System reset, active low |
| lowline_n | output | 1 | Primary low flag, active low |
| secfail_n | output | 1 | Secondary fail flag, active low |
| bus_inhibit | output | 1 | Blocks serial traffic while reset is active |

## Verification
A stretch counter that is wrong shows up as a release that is early or late by whole ticks. That error is visible at `rst_n` at the first release after the fault. A counter that fails to clear on a reasserted cause shows up as a short stretch in the restart sweep. A debounce state that is wrong shows up either as a glitch that resets the system or as a release that comes DEBOUNCE_TICKS off from the expected point. Both are seen within one request-and-release sequence.

// File: rtl/supv_reset_seq.sv
module supv_reset_seq #(
  parameter int STRETCH_TICKS  = 200,
  parameter int DEBOUNCE_TICKS = 10
) (
  input  logic clk,
  input  logic por_n,
  input  logic tick,
  input  logic pri_low,
  input  logic sec_low,
  input  logic mrst_n,
  output logic rst_n,
  output logic lowline_n,
  output logic secfail_n,
  output logic bus_inhibit
);
  localparam int SW = $clog2(STRETCH_TICKS + 1);
  localparam int DW = $clog2(DEBOUNCE_TICKS + 1);
  localparam logic [SW-1:0] S_LAST = SW'(STRETCH_TICKS - 1);
  localparam logic [DW-1:0] D_LAST = DW'(DEBOUNCE_TICKS - 1);

  logic [1:0]    mr_sync;
  logic          mr_act;
  logic [DW-1:0] dcnt;
  logic          hold;
  logic [SW-1:0] scnt;
  logic          cause;

  wire mr_low_s = ~mr_sync[1];
  assign cause = pri_low | mr_act;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) mr_sync <= 2'b11;
    else        mr_sync <= {mr_sync[0], mrst_n};

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      mr_act <= 1'b0;
      dcnt   <= '0;
    end else if (mr_low_s == mr_act) begin
      dcnt <= '0;
    end else if (tick) begin
      if (dcnt == D_LAST) begin
        mr_act <= mr_low_s;
        dcnt   <= '0;
      end else begin
        dcnt <= dcnt + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      hold <= 1'b1;
      scnt <= '0;
    end else if (cause) begin
      hold <= 1'b1;
      scnt <= '0;
    end else if (hold && tick) begin
      if (scnt == S_LAST) begin
        hold <= 1'b0;
        scnt <= '0;
      end else begin
        scnt <= scnt + 1'b1;
      end
    end

  assign rst_n       = ~(hold | cause);
  assign bus_inhibit = hold | cause;
  assign lowline_n   = ~pri_low;
  assign secfail_n   = ~sec_low;
endmodule

// File: rtl/supv_reset_seq_chk.sv
module supv_reset_seq_chk #(
  parameter int STRETCH_TICKS = 200
) (
  input logic clk,
  input logic por_n,
  input logic tick,
  input logic pri_low,
  input logic sec_low,
  input logic mr_act,
  input logic rst_n,
  input logic lowline_n,
  input logic secfail_n,
  input logic bus_inhibit
);
  int quiet;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)                 quiet <= 0;
    else if (pri_low || mr_act) quiet <= 0;
    else if (!rst_n && tick)    quiet <= quiet + 1;
    else if (rst_n)             quiet <= 0;

  assert_pri_forces_R1: assert property (@(posedge clk) disable iff (!por_n)
    pri_low |-> !rst_n);
  assert_stretch_len_R2: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_n) |-> quiet == STRETCH_TICKS);
  assert_release_on_tick_R9: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_n) |-> $past(tick) && !$past(pri_low));
  assert_lowline_in_reset_R6: assert property (@(posedge clk) disable iff (!por_n)
    !lowline_n |-> !rst_n);
  assert_secfail_follow_R7: assert property (@(posedge clk) disable iff (!por_n)
    (sec_low != $past(sec_low)) |-> (secfail_n != $past(secfail_n)));
  assert_inhibit_edge_R8: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_n) |-> $fell(bus_inhibit));
endmodule

bind supv_reset_seq supv_reset_seq_chk #(.STRETCH_TICKS(STRETCH_TICKS)) u_chk (
  .clk(clk), .por_n(por_n), .tick(tick), .pri_low(pri_low), .sec_low(sec_low),
  .mr_act(mr_act), .rst_n(rst_n), .lowline_n(lowline_n), .secfail_n(secfail_n),
  .bus_inhibit(bus_inhibit)
);

// File: tb/tb_supv_reset_seq.sv
module tb_supv_reset_seq;
  localparam int S = 5;
  localparam int D = 3;

  logic clk = 0, por_n = 0, tick = 0, pri_low = 0, sec_low = 0, mrst_n = 1;
  logic rst_n, lowline_n, secfail_n, bus_inhibit;
  int total = 0, bad = 0;
  bit done = 0;

  supv_reset_seq #(.STRETCH_TICKS(S), .DEBOUNCE_TICKS(D)) dut (
    .clk(clk), .por_n(por_n), .tick(tick), .pri_low(pri_low), .sec_low(sec_low),
    .mrst_n(mrst_n), .rst_n(rst_n), .lowline_n(lowline_n), .secfail_n(secfail_n),
    .bus_inhibit(bus_inhibit));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick = 1;
    @(negedge clk) tick = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks_to_release(output int n);
    n = 0;
    while (rst_n == 0 && n < 100) begin
      pulse_tick();
      idle(1);
      n++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    int n;
    idle(3);
    chk(rst_n == 0, "R3 reset state", rst_n, 0);
    chk(bus_inhibit == 1, "R8 reset state", bus_inhibit, 1);
    @(negedge clk) por_n = 1;
    idle(4);
    chk(rst_n == 0, "R3 held without ticks", rst_n, 0);
    ticks_to_release(n);
    chk(n == S, "R3 power-up stretch", n, S);
    chk(bus_inhibit == 0, "R8 released", bus_inhibit, 0);

    for (int p = 0; p < 2; p++)
      for (int s = 0; s < 2; s++) begin
        @(negedge clk) begin pri_low = p[0]; sec_low = s[0]; end
        #1;
        chk(lowline_n == !p[0], "R6 lowline", lowline_n, !p[0]);
        chk(secfail_n == !s[0], "R7 secfail", secfail_n, !s[0]);
        chk(rst_n == !p[0], "R1 pri forces", rst_n, !p[0]);
        chk(bus_inhibit == p[0], "R8 inhibit", bus_inhibit, p[0]);
        if (p == 1) begin
          @(negedge clk) pri_low = 0;
          #1 chk(lowline_n == 1, "R6 no stretch", lowline_n, 1);
          chk(rst_n == 0, "R2 stretch active", rst_n, 0);
          ticks_to_release(n);
          chk(n == S, "R2 stretch length", n, S);
        end
      end
    sec_low = 0;

    for (int k = 0; k < S; k++) begin
      @(negedge clk) pri_low = 1;
      @(negedge clk) pri_low = 0;
      for (int j = 0; j < k; j++) pulse_tick();
      idle(1);
      chk(rst_n == 0, "R9 before reassert", rst_n, 0);
      @(negedge clk) pri_low = 1;
      @(negedge clk) pri_low = 0;
      ticks_to_release(n);
      chk(n == S, "R9 restart", n, S);
    end

    for (int g = 1; g < D; g++) begin
      @(negedge clk) mrst_n = 0;
      idle(3);
      for (int j = 0; j < g; j++) pulse_tick();
      @(negedge clk) mrst_n = 1;
      idle(3);
      for (int j = 0; j < D + 1; j++) begin
        pulse_tick();
        chk(rst_n == 1, "R5 short glitch ignored", rst_n, 1);
      end
    end

    @(negedge clk) mrst_n = 0;
    idle(3);
    for (int j = 0; j < D - 1; j++) pulse_tick();
    idle(1);
    chk(rst_n == 1, "R5 not yet accepted", rst_n, 1);
    pulse_tick();
    idle(1);
    chk(rst_n == 0, "R4 manual asserts", rst_n, 0);
    for (int j = 0; j < 2 * S; j++) pulse_tick();
    chk(rst_n == 0, "R4 held while pressed", rst_n, 0);
    @(negedge clk) mrst_n = 1;
    idle(3);
    ticks_to_release(n);
    chk(n == D + S, "R4 release debounce plus stretch", n, D + S);

    @(negedge clk) sec_low = 1;
    @(negedge clk) mrst_n = 0;
    idle(3);
    for (int j = 0; j < D; j++) pulse_tick();
    idle(1);
    chk(secfail_n == 0 && rst_n == 0, "R7 secfail during reset", secfail_n, 0);
    @(negedge clk) begin mrst_n = 1; sec_low = 0; end
    #1 chk(secfail_n == 1, "R7 secfail clears", secfail_n, 1);
    idle(3);
    ticks_to_release(n);
    chk(n == D + S, "R4 second release", n, D + S);

    finish_run();
  end
endmodule